// File: doc/BRIEF.md
# Four-Instruction Accumulator Processor

This block is a very small processor core built around one 8-bit accumulator. It has a 6-bit program counter and a single carry flag. Program and data share one 64-byte memory, which the core reaches through one port. Every instruction is a single byte. The top two bits select the operation, and the lower six bits hold an absolute memory address. The core knows four operations: bitwise NOR into the accumulator, add into the accumulator with carry-out, store the accumulator, and jump when carry is clear. Complement, negate, compare, shift and zero tests are all built in software from these four.

The memory port is plain, with no handshake. The core drives an address at all times. Read data is expected back in the same cycle, so the memory must have a combinational read path. A write takes effect on the clock edge that ends a cycle in which the write enable is high. NOR, ADD and store take two cycles: a fetch cycle and an operand cycle. The conditional jump is finished within its fetch cycle. An asynchronous active-low reset clears the program counter, the accumulator and the carry flag, so execution starts from address 0.

Top module: `cpu4_core`

## Requirements
- R1: While reset is low, and in the first cycle after reset is released, the core fetches from address 0 with the write enable low. Reset clears the accumulator to 0x00 and the carry flag to 0.
- R2: An instruction byte is decoded as follows. Bits [7:6] give the operation: 00 NOR, 01 ADD, 10 store, 11 jump-if-carry-clear. Bits [5:0] give the absolute target or operand address.
- R3: NOR replaces the accumulator with the bitwise NOR of the accumulator and the operand byte. The carry flag is left unchanged.
- R4: ADD replaces the accumulator with the low 8 bits of accumulator plus operand. The carry flag takes bit 8 of that sum. As a consequence, adding 0xFF to a zero accumulator leaves carry clear.
- R5: Store writes the accumulator to the addressed byte. The write enable is high for exactly that one cycle, and the accumulator and carry flag are left unchanged.
- R6: A jump whose carry flag is clear loads the program counter with its 6-bit target. The next cycle fetches from that target, and no memory write takes place.
- R7: A jump whose carry flag is set falls through to the next address and clears the carry flag.
- R8: NOR, ADD and store each take two cycles. The fetch cycle drives the program counter as the address. The operand cycle drives the latched address field. The jump takes one cycle.
- R9: The program counter wraps from 63 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 6 | Memory address: the program counter in fetch cycles, the operand address in operand cycles |
| mem_wdata | output | 8 | Data to be stored; meaningful only when mem_we is high |
| mem_we | output | 1 | Write strobe for the store operand cycle |
| mem_rdata | input | 8 | Byte read from mem_addr in the same cycle |

## Verification
The add sweep covers a grid of operand pairs that includes 0x00, 0xFF and the overflow edge. If the carry were taken from the wrong bit, the wrong path would be chosen by the jump that follows, and that path's store would be missing or misplaced. A separate sequence sets carry, runs a NOR, and then relies on a jump to see whether carry survived the NOR and whether it was cleared on fall-through. A design that lost carry in NOR, or kept it after the jump, would execute a store that the bench watches for. Other tests check an asynchronous reset after a run that leaves the accumulator and carry dirty, and the wrap of the program counter from 63 to 0. An address trace is compared cycle by cycle, which catches a jump that takes two cycles or a store that lands at the wrong time.

// File: rtl/cpu4_pkg.sv
package cpu4_pkg;
  typedef enum logic [1:0] {
    OP_NOR = 2'b00,
    OP_ADD = 2'b01,
    OP_STA = 2'b10,
    OP_JCC = 2'b11
  } op_e;

  typedef enum logic {
    PH_FETCH = 1'b0,
    PH_EXEC  = 1'b1
  } phase_e;
endpackage

// File: rtl/cpu4_alu.sv
module cpu4_alu #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] opnd,
  output logic [DW-1:0] nor_res,
  output logic [DW:0]   sum
);
  // per-bit NOR lanes
  for (genvar b = 0; b < DW; b++) begin : g_nor
    assign nor_res[b] = ~(acc[b] | opnd[b]);
  end
  assign sum = {1'b0, acc} + {1'b0, opnd};
endmodule

// File: rtl/cpu4_seq.sv
module cpu4_seq
  import cpu4_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] rdata,
  input  logic          carry,
  output logic          in_exec,
  output op_e           op_q,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] addr,
  output logic          jcc_fall
);
  localparam int OPW = DW - AW;

  phase_e        phase_q;
  logic [AW-1:0] adr_q;
  op_e           fetch_op;
  logic [AW-1:0] target;

  assign fetch_op = op_e'(rdata[DW-1 -: OPW]);
  assign target   = rdata[AW-1:0];
  assign in_exec  = (phase_q == PH_EXEC);
  assign addr     = in_exec ? adr_q : pc_q;
  assign jcc_fall = !in_exec && (fetch_op == OP_JCC) && carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FETCH;
      pc_q    <= '0;
      adr_q   <= '0;
      op_q    <= OP_NOR;
    end else if (!in_exec) begin
      if (fetch_op == OP_JCC) begin
        pc_q <= carry ? pc_q + 1'b1 : target;
      end else begin
        adr_q   <= target;
        op_q    <= fetch_op;
        pc_q    <= pc_q + 1'b1;
        phase_q <= PH_EXEC;
      end
    end else begin
      phase_q <= PH_FETCH;
    end
  end
endmodule

// File: rtl/cpu4_accum.sv
module cpu4_accum
  import cpu4_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_exec,
  input  op_e           op,
  input  logic          jcc_fall,
  input  logic [DW-1:0] nor_res,
  input  logic [DW:0]   sum,
  output logic [DW-1:0] acc_q,
  output logic          carry_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else if (in_exec) begin
      case (op)
        OP_NOR:  acc_q <= nor_res;
        OP_ADD:  {carry_q, acc_q} <= sum;
        default: ;
      endcase
    end else if (jcc_fall) begin
      carry_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cpu4_core.sv
module cpu4_core
  import cpu4_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata
);
  logic          in_exec;
  op_e           op_q;
  logic [AW-1:0] pc_q;
  logic          jcc_fall;
  logic [DW-1:0] acc_q;
  logic          carry_q;
  logic [DW-1:0] nor_res;
  logic [DW:0]   sum;

  cpu4_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .rdata(mem_rdata), .carry(carry_q),
    .in_exec(in_exec), .op_q(op_q), .pc_q(pc_q), .addr(mem_addr),
    .jcc_fall(jcc_fall)
  );

  cpu4_alu #(.DW(DW)) u_alu (
    .acc(acc_q), .opnd(mem_rdata), .nor_res(nor_res), .sum(sum)
  );

  cpu4_accum #(.DW(DW)) u_accum (
    .clk(clk), .rst_n(rst_n), .in_exec(in_exec), .op(op_q),
    .jcc_fall(jcc_fall), .nor_res(nor_res), .sum(sum),
    .acc_q(acc_q), .carry_q(carry_q)
  );

  assign mem_we    = in_exec && (op_q == OP_STA);
  assign mem_wdata = acc_q;
endmodule

// File: rtl/cpu4_checker.sv
module cpu4_checker #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic [DW-1:0] mem_rdata,
  input logic [AW-1:0] pc,
  input logic [DW-1:0] acc,
  input logic          carry,
  input logic          in_exec,
  input logic [1:0]    op
);
  logic is_jcc;
  assign is_jcc = (mem_rdata[DW-1 -: 2] == 2'b11);

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_idle: assert (mem_addr == '0 && !mem_we && acc == '0 && !carry);
    end
  end

  a_r2_operand_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_exec && !is_jcc) |=> (in_exec && mem_addr == $past(mem_rdata[AW-1:0])));

  a_r8_exec_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    in_exec |=> !in_exec);

  a_r3_nor: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && op == 2'b00) |=>
      (acc == ~($past(acc) | $past(mem_rdata)) && carry == $past(carry)));

  a_r4_add: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && op == 2'b01) |=>
      ({carry, acc} == ({1'b0, $past(acc)} + {1'b0, $past(mem_rdata)})));

  a_r5_store_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (!mem_we && acc == $past(acc) && carry == $past(carry)));

  a_r6_jump_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_exec && is_jcc && !carry) |=>
      (!in_exec && mem_addr == $past(mem_rdata[AW-1:0])));

  a_r7_jump_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_exec && is_jcc && carry) |=>
      (!in_exec && !carry && pc == AW'($past(pc) + 1'b1)));
endmodule

bind cpu4_core cpu4_checker #(.AW(AW), .DW(DW)) u_cpu4_checker (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
  .mem_rdata(mem_rdata), .pc(pc_q), .acc(acc_q), .carry(carry_q),
  .in_exec(in_exec), .op(op_q)
);

// File: tb/test_cpu4_core.sv
module test_cpu4_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] mem_addr;
  logic [7:0] mem_wdata;
  logic       mem_we;
  logic [7:0] mem_rdata;

  logic [7:0] mem [64];
  logic [5:0] tr_addr [40];
  logic       tr_we [40];
  int n_tot = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  cpu4_core i_cpu4_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  function automatic logic [7:0] ins(input int op, input int a);
    return {op[1:0], a[5:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tot++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
  endtask

  // reset asserted at a negedge (between edges), program already loaded
  task automatic enter_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #2;
  endtask

  task automatic run(input int n);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < n; k++) begin
      tr_addr[k] = mem_addr;
      tr_we[k]   = mem_we;
      @(negedge clk);
    end
  endtask

  initial begin
    logic [8:0] s;
    bit         tr_ok;
    enter_reset();
    clear_mem();
    mem[0] = ins(2, 20);
    @(negedge clk);
    // R1: reset state at the port
    chk(mem_addr == 6'd0 && !mem_we, "R1 reset port idle",
        {mem_addr, mem_we}, 0);

    // ADD sweep: R4 sum and carry, R6/R7 via jump path, R8 timing
    for (int i = 0; i < 18; i++) begin
      for (int j = 0; j < 18; j++) begin
        int a = i * 15;
        int b = j * 15 + ((j == 1) ? 1 : 0);
        enter_reset();
        clear_mem();
        s = 9'(a) + 9'(b);
        mem[0] = ins(1, 60); mem[1] = ins(1, 61); mem[2] = ins(2, 62);
        mem[3] = ins(3, 6);  mem[4] = ins(2, 58); mem[5] = ins(3, 5);
        mem[6] = ins(3, 6);
        mem[60] = 8'(a); mem[61] = 8'(b);
        mem[62] = ~s[7:0]; mem[58] = ~s[7:0];
        run(12);
        chk(mem[62] == s[7:0], "R4 sum", mem[62], s[7:0]);
        chk(mem[58] == (s[8] ? s[7:0] : ~s[7:0]), "R4 carry (R6/R7 path)",
            mem[58], s[8] ? s[7:0] : ~s[7:0]);
        tr_ok = tr_addr[0] == 0 && tr_addr[1] == 60 && tr_addr[2] == 1 &&
                tr_addr[3] == 61 && tr_addr[4] == 2 && tr_addr[5] == 62 &&
                tr_we[5] && !tr_we[4] && !tr_we[6] && tr_addr[6] == 3;
        chk(tr_ok, "R8 two-cycle trace", tr_addr[5], 62);
        if (s[8]) chk(tr_addr[7] == 4 && !tr_we[7], "R7 fall-through", tr_addr[7], 4);
        else      chk(tr_addr[7] == 6 && !tr_we[7], "R6 taken jump", tr_addr[7], 6);
      end
    end

    // NOR sweep with store-keeps-accumulator (R3, R5)
    for (int i = 0; i < 18; i++) begin
      for (int j = 0; j < 18; j++) begin
        int a = i * 15;
        int b = 255 - j * 15;
        logic [7:0] nx;
        enter_reset();
        clear_mem();
        nx = ~(8'(a) | 8'(b));
        mem[0] = ins(1, 60); mem[1] = ins(2, 56); mem[2] = ins(0, 61);
        mem[3] = ins(2, 62); mem[4] = ins(3, 4);
        mem[60] = 8'(a); mem[61] = 8'(b);
        mem[56] = ~8'(a); mem[62] = ~nx;
        run(12);
        chk(mem[56] == 8'(a), "R5 store value", mem[56], a);
        chk(mem[62] == nx, "R3 nor result", mem[62], nx);
      end
    end

    // R3 carry kept across NOR, R7 clears carry
    enter_reset();
    clear_mem();
    mem[0] = ins(1, 60); mem[1] = ins(1, 60); mem[2] = ins(0, 61);
    mem[3] = ins(3, 5);  mem[4] = ins(2, 62); mem[5] = ins(3, 5);
    mem[6] = ins(2, 63);
    mem[60] = 8'hFF; mem[61] = 8'h01; mem[62] = 8'h77; mem[63] = 8'h77;
    run(14);
    chk(mem[62] == 8'h00, "R3 carry kept through nor", mem[62], 0);
    chk(mem[63] == 8'h77, "R7 carry cleared on fall", mem[63], 8'h77);
    chk(tr_addr[6] == 3 && tr_addr[7] == 4 && tr_addr[10] == 5 && tr_addr[11] == 5,
        "R7 one-cycle jump trace", tr_addr[10], 5);

    // leave acc and carry dirty, then R1 reset clears them
    enter_reset();
    clear_mem();
    mem[0] = ins(1, 60); mem[1] = ins(1, 60);
    mem[60] = 8'hFF;
    run(6);
    enter_reset();
    chk(mem_addr == 6'd0 && !mem_we, "R1 async reset mid-run", mem_addr, 0);
    clear_mem();
    mem[0] = ins(2, 40); mem[1] = ins(3, 3); mem[2] = ins(2, 41);
    mem[3] = ins(3, 3);
    mem[40] = 8'h33; mem[41] = 8'h33;
    run(8);
    chk(tr_addr[0] == 0, "R1 first fetch at 0", tr_addr[0], 0);
    chk(mem[40] == 8'h00, "R1 accumulator cleared", mem[40], 0);
    chk(mem[41] == 8'h33 && tr_addr[3] == 3, "R1 carry cleared", mem[41], 8'h33);

    // R9 program counter wrap, R2 field decode of addresses
    enter_reset();
    clear_mem();
    mem[0] = ins(3, 62); mem[62] = ins(1, 50); mem[63] = ins(2, 51);
    mem[50] = 8'h05; mem[51] = 8'hEE;
    run(6);
    chk(tr_addr[1] == 62 && tr_addr[2] == 50, "R2 decode of target/operand",
        tr_addr[2], 50);
    chk(tr_addr[4] == 51 && tr_we[4] && mem[51] == 8'h05, "R5 store at 51",
        mem[51], 5);
    chk(tr_addr[5] == 0, "R9 wrap 63 to 0", tr_addr[5], 0);

    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_tot++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule